// File: doc/BRIEF.md
# Adjacent Row Refresh Trigger

This block sits beside a DRAM controller and protects rows from disturbance errors caused by hammering a neighbouring row. Each time the controller closes (precharges) a row, it reports the bank and row on a one-cycle strobe. The block then takes a pseudo-random decision. With a small fixed probability, about one in a thousand, it asks the controller to activate the two physically adjacent rows. Activating those rows restores their charge.

The block keeps no activation counters and no per-row state. Protection is statistical. A row that is opened and closed many times within one 64 ms refresh window is almost certain to have its neighbours refreshed several times. Random bits come from a free-running linear feedback shift register (LFSR). Pending refresh requests wait in a small queue. The controller drains that queue through a valid/ready handshake. When the queue cannot take a new trigger, the trigger is dropped and a saturating counter records the loss.

Top module: `adj_row_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `req_valid` is 0 and `drop_count` is 0. Reset loads the LFSR with `LFSR_SEED`.
- R2: The LFSR is `LFSR_W` bits wide and shifts left on every clock edge out of reset, whether or not a row closes. The bit shifted in is the XOR of the bits selected by `LFSR_TAPS`. With the default taps, mask 0xD008 (bits 15, 14, 12, 3), the sequence has maximal length.
- R3: A row close at an edge where the LFSR's current value is below `THRESH` is a trigger. A row close at any other edge leaves the queue and `drop_count` unchanged. With `THRESH`=64 and a 16-bit LFSR, the trigger rate is 1/1024.
- R4: A trigger for row r in bank b, with 0 < r < 2^ROW_W-1, queues two entries in this order: (b, r-1), then (b, r+1).
- R5: At the array edges only the existing neighbour is queued. Row 0 queues only (b, 1). Row 2^ROW_W-1 queues only (b, 2^ROW_W-2).
- R6: `req_valid` is high exactly when the queue is non-empty, and `req_bank`/`req_row` show the oldest entry. An entry leaves the queue on an edge with `req_valid` and `req_ready` both high. While `req_ready` is low, the head stays unchanged.
- R7: A trigger whose entries do not all fit in the free slots queues nothing. Free slots are counted before that edge's pop. Such a dropped trigger adds 1 to `drop_count`, which saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| close_valid | input | 1 | One-cycle strobe: a row was closed |
| close_bank | input | BANK_W | Bank of the closed row |
| close_row | input | ROW_W | Address of the closed row |
| req_valid | output | 1 | A refresh activation is pending |
| req_ready | input | 1 | Controller accepts the pending request |
| req_bank | output | BANK_W | Bank to activate |
| req_row | output | ROW_W | Row to activate |
| drop_count | output | DROP_W | Saturating count of dropped triggers |

## Verification
The bench builds the block with `THRESH`=16384, which makes about one close in four a trigger. This raises queueing, draining and overflow from rare events to common ones within a few thousand cycles.

The bench uses `ROW_W`=6, so edge rows 0 and 63 turn up often in random traffic. It uses `DEPTH`=4, so the queue fills after two interior triggers. It uses `DROP_W`=4, so a long stall with `req_ready` held low drives `drop_count` into saturation.

// File: rtl/adj_row_guard.sv
module adj_row_guard #(
  parameter int unsigned ROW_W     = 16,
  parameter int unsigned BANK_W    = 3,
  parameter int unsigned LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hD008,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter int unsigned THRESH    = 64,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned DROP_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close_valid,
  input  logic [BANK_W-1:0] close_bank,
  input  logic [ROW_W-1:0]  close_row,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [BANK_W-1:0] req_bank,
  output logic [ROW_W-1:0]  req_row,
  output logic [DROP_W-1:0] drop_count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned ENT_W = BANK_W + ROW_W;
  localparam logic [LFSR_W:0] THR = THRESH[LFSR_W:0];
  localparam logic [ROW_W-1:0] ROW_LAST = {ROW_W{1'b1}};
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [LFSR_W-1:0] lfsr;
  logic [ENT_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0]  wptr, rptr;
  logic [CNT_W-1:0]  count;

  wire fb     = ^(lfsr & LFSR_TAPS);
  wire hit    = ({1'b0, lfsr} < THR);
  wire fire   = close_valid && hit;
  wire at_low = (close_row == '0);
  wire at_top = (close_row == ROW_LAST);
  wire [CNT_W-1:0] need = (at_low || at_top) ? CNT_W'(1) : CNT_W'(2);
  wire [CNT_W-1:0] free = CAP - count;
  wire accept = fire && (free >= need);
  wire drop   = fire && !accept;
  wire pop    = req_valid && req_ready;

  wire [ENT_W-1:0] ent_lo = {close_bank, close_row - ROW_W'(1)};
  wire [ENT_W-1:0] ent_hi = {close_bank, close_row + ROW_W'(1)};
  wire [ENT_W-1:0] first  = at_low ? ent_hi : ent_lo;

  assign req_valid = (count != '0);
  assign {req_bank, req_row} = mem[rptr];

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {lfsr[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mem[wptr] <= first;
      if (need == CNT_W'(2)) mem[wptr + PTR_W'(1)] <= ent_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= wptr + PTR_W'(need);
      if (pop)    rptr <= rptr + PTR_W'(1);
      count <= count + (accept ? need : CNT_W'(0)) - (pop ? CNT_W'(1) : CNT_W'(0));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          drop_count <= '0;
    else if (drop && !(&drop_count))     drop_count <= drop_count + DROP_W'(1);
  end
endmodule

// File: rtl/adj_row_guard_chk.sv
module adj_row_guard_chk #(
  parameter int unsigned ROW_W  = 16,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned LFSR_W = 16,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DROP_W = 16,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              close_valid,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [ROW_W-1:0]  req_row,
  input logic [DROP_W-1:0] drop_count,
  input logic [LFSR_W-1:0] lfsr,
  input logic [CNT_W-1:0]  count
);
  a_r2_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  a_r2_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> lfsr != $past(lfsr));

  a_r6_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_row) && $stable(req_bank)));

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  a_r7_drop_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> drop_count >= $past(drop_count));

  a_r7_drop_needs_close: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((drop_count == $past(drop_count)) || $past(close_valid)));

  a_r3_no_growth_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !close_valid |=> count <= $past(count));
endmodule

bind adj_row_guard adj_row_guard_chk #(
  .ROW_W(ROW_W), .BANK_W(BANK_W), .LFSR_W(LFSR_W),
  .DEPTH(DEPTH), .DROP_W(DROP_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .close_valid(close_valid),
  .req_valid(req_valid), .req_ready(req_ready),
  .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count),
  .lfsr(lfsr), .count(count)
);

// File: tb/sim_adj_row_guard.sv
module sim_adj_row_guard;
  localparam int ROW_W = 6, BANK_W = 2, LFSR_W = 16, DEPTH = 4, DROP_W = 4;
  localparam int THRESH = 16384;
  localparam logic [15:0] TAPS = 16'hD008, SEED = 16'hACE1;
  localparam int ROW_MAX = (1 << ROW_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic close_valid = 1'b0, req_ready = 1'b0;
  logic [BANK_W-1:0] close_bank = '0;
  logic [ROW_W-1:0]  close_row = '0;
  logic req_valid;
  logic [BANK_W-1:0] req_bank;
  logic [ROW_W-1:0]  req_row;
  logic [DROP_W-1:0] drop_count;

  int checks = 0, fails = 0;
  bit done = 0;

  adj_row_guard #(.ROW_W(ROW_W), .BANK_W(BANK_W), .LFSR_W(LFSR_W), .LFSR_TAPS(TAPS),
    .LFSR_SEED(SEED), .THRESH(THRESH), .DEPTH(DEPTH), .DROP_W(DROP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .close_valid(close_valid), .close_bank(close_bank),
    .close_row(close_row), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .drop_count(drop_count));

  always #5 clk = ~clk;

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], ^(s & TAPS)};
  endfunction

  logic [15:0] m_lfsr = SEED;
  int m_q[$];
  int m_drop = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = SEED; m_q.delete(); m_drop = 0;
    end else begin
      int occ, need, r;
      occ = m_q.size();
      if (occ > 0 && req_ready) void'(m_q.pop_front());
      if (close_valid && m_lfsr < THRESH) begin
        r = close_row;
        need = (r == 0 || r == ROW_MAX) ? 1 : 2;
        if (DEPTH - occ >= need) begin
          if (r != 0)       m_q.push_back((close_bank << ROW_W) | (r - 1));
          if (r != ROW_MAX) m_q.push_back((close_bank << ROW_W) | (r + 1));
        end else if (m_drop < (1 << DROP_W) - 1) m_drop++;
      end
      m_lfsr = lfsr_next(m_lfsr);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(req_valid == (m_q.size() != 0), "R6 req_valid", req_valid, m_q.size() != 0);
    if (m_q.size() != 0 && req_valid)
      chk({req_bank, req_row} == m_q[0][BANK_W+ROW_W-1:0], "R4/R5 head entry",
          {req_bank, req_row}, m_q[0]);
    chk(drop_count == m_drop, "R7 drop_count", drop_count, m_drop);
  end

  task automatic close_when(input bit want_hit, input int bank, input int row);
    while ((m_lfsr < THRESH) != want_hit) @(negedge clk);
    close_valid = 1'b1; close_bank = BANK_W'(bank); close_row = ROW_W'(row);
    @(negedge clk);
    close_valid = 1'b0;
  endtask

  task automatic drain();
    req_ready = 1'b1;
    while (req_valid) @(negedge clk);
    req_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 valid in reset", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == 1'b0, "R1 valid after reset", req_valid, 0);
    chk(drop_count == 0, "R1 drop_count after reset", drop_count, 0);

    close_when(1'b0, 1, 10);
    chk(req_valid == 1'b0, "R3 miss queues nothing", req_valid, 0);

    close_when(1'b1, 2, 10);
    chk(req_valid && req_row == 9 && req_bank == 2, "R4 lower first", req_row, 9);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk(req_valid && req_row == 11, "R4 upper second", req_row, 11);
    drain();

    close_when(1'b1, 3, 0);
    chk(req_valid && req_row == 1, "R5 row 0 neighbour", req_row, 1);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk(!req_valid, "R5 row 0 single entry", req_valid, 0);

    close_when(1'b1, 0, ROW_MAX);
    chk(req_valid && req_row == ROW_MAX - 1, "R5 top row neighbour", req_row, ROW_MAX - 1);
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk(!req_valid, "R5 top row single entry", req_valid, 0);

    close_when(1'b1, 1, 20);
    close_when(1'b1, 1, 30);
    close_when(1'b1, 1, 40);
    chk(drop_count == 1, "R7 overflow dropped", drop_count, 1);
    chk(req_valid && req_row == 19, "R7 queue kept older entries", req_row, 19);
    drain();

    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      close_valid = ($urandom_range(0, 1) == 1);
      close_bank = BANK_W'($urandom);
      close_row = (sel == 0) ? '0 : (sel == 1) ? ROW_W'(ROW_MAX) : ROW_W'($urandom);
      req_ready = (i % 400 < 200) ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
      @(negedge clk);
    end
    close_valid = 1'b0; req_ready = 1'b0;

    for (int i = 0; i < 40; i++) close_when(1'b1, 1, 5 + i);
    chk(drop_count == (1 << DROP_W) - 1, "R7 saturation", drop_count, (1 << DROP_W) - 1);
    drain();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule